// File: doc/BRIEF.md
# UART FIFO control logic

This block holds the transmit and receive byte queues of a 16550-style UART together with the write-only control register that drives them. The host writes the control register to switch between queued operation (sixteen entries per direction by default) and single-byte holding-register operation, and to flush either queue with a self-clearing command. The host side pushes transmit bytes and pops received entries. The serial side pops transmit bytes and pushes received characters with their parity, framing and break flags.

The block reports queue levels, the oldest entry of each queue, the data-ready and transmit-request flags, an error summary over the stored receive entries, and the two interrupt causes. Sticky line-status flags record overrun, parity, framing and break events. A line-status read clears them, and a queue flush leaves them alone.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the block is in single-byte mode (`fifo_mode`=0), both levels are 0, `data_ready`=0, `tx_req`=1, `fifo_err`=0 and all four sticky line flags are 0.
- R2: A control write with bit 0 = 0 sets `fifo_mode` to 0 and empties both queues at the same clock edge, whatever the other bits hold.
- R3: A control write that changes bit 0 from the current mode empties both queues at the edge where the mode changes.
- R4: With bit 0 = 1 and the mode unchanged, control bit 1 = 1 empties only the receive queue and bit 2 = 1 empties only the transmit queue. The other queue keeps its level. Writing 0 to bits 1 and 2 has no effect.
- R5: Capacity is DEPTH entries when `fifo_mode`=1 and 1 entry when it is 0. A push into a full queue is discarded, and a pop from an empty queue is ignored. Entries leave in the order they arrived. Fullness is judged on the level before the clock edge.
- R6: A receive push refused because the queue is full sets `ls_oe`.
- R7: `tx_req` is 1 exactly when the transmit queue is empty, so a transmit flush raises it. `irq_tx_req` = `tx_ie` AND `tx_req`.
- R8: A receive flush clears `data_ready`, `fifo_err` and `irq_rx_data` (= `rx_ie` AND `data_ready`). It does not clear the sticky `ls_oe`, `ls_pe`, `ls_fe` or `ls_bi`.
- R9: `fifo_err` is 1 exactly when at least one stored receive entry carries a parity, framing or break flag.
- R10: A flush and a push to the same queue in the same cycle leave that queue's level at 0, and the pushed entry is lost.
- R11: An accepted receive push sets `ls_pe`, `ls_fe` and `ls_bi` from its flags. `lsr_clr` clears all four sticky flags, but a set in the same cycle wins over the clear.
- R12: `rx_head_data`, `rx_head_pe`, `rx_head_fe`, `rx_head_bi` and `tx_head` present the oldest stored entry whenever the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control bits: 0 queue enable, 1 receive flush, 2 transmit flush |
| tx_ie | input | 1 | Transmit-request interrupt enable |
| rx_ie | input | 1 | Received-data interrupt enable |
| tx_push | input | 1 | Host writes a transmit byte |
| tx_din | input | 8 | Transmit byte |
| tx_pop | input | 1 | Shift register takes the oldest transmit byte |
| rx_push | input | 1 | Shift register delivers a received character |
| rx_din | input | 8 | Received character |
| rx_din_pe | input | 1 | Parity error flag of the received character |
| rx_din_fe | input | 1 | Framing error flag of the received character |
| rx_din_bi | input | 1 | Break flag of the received character |
| rx_pop | input | 1 | Host reads the oldest received entry |
| lsr_clr | input | 1 | Line-status read, clears the sticky flags |
| fifo_mode | output | 1 | 1 = queued mode, 0 = single-byte mode |
| tx_level | output | CNT_W | Transmit queue level |
| tx_head | output | 8 | Oldest transmit byte |
| tx_req | output | 1 | Transmit queue empty |
| irq_tx_req | output | 1 | Transmit-request interrupt cause |
| rx_level | output | CNT_W | Receive queue level |
| rx_head_data | output | 8 | Oldest received character |
| rx_head_pe | output | 1 | Parity flag of the oldest entry |
| rx_head_fe | output | 1 | Framing flag of the oldest entry |
| rx_head_bi | output | 1 | Break flag of the oldest entry |
| data_ready | output | 1 | Receive queue not empty |
| fifo_err | output | 1 | Some stored receive entry has an error flag |
| irq_rx_data | output | 1 | Received-data interrupt cause |
| ls_oe | output | 1 | Sticky overrun |
| ls_pe | output | 1 | Sticky parity error |
| ls_fe | output | 1 | Sticky framing error |
| ls_bi | output | 1 | Sticky break |

## Verification
The bench builds the block with the default DEPTH of 16. At that depth seventeen back-to-back pushes reach the overrun path, and long random traffic wraps the four-bit pointers many times, both in queued and in single-byte mode. The small depth also puts flushes that coincide with pushes, pops and mode changes within reach of a few thousand random cycles. Each flush leaves the queues at different levels and with error entries at different positions.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int UCF_DATA_W  = 8;
    localparam int UCF_CFG_W   = 3;
    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_RXF_BIT = 1;
    localparam int CFG_TXF_BIT = 2;

    typedef struct packed {
        logic                  brk;
        logic                  ferr;
        logic                  perr;
        logic [UCF_DATA_W-1:0] data;
    } rx_word_t;

    function automatic logic rx_word_bad(rx_word_t w);
        return w.brk | w.ferr | w.perr;
    endfunction

endpackage

// File: rtl/ucf_ctrl.sv
module ucf_ctrl
    import uart_fifo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [UCF_CFG_W-1:0] wdata,
    output logic                 fifo_en,
    output logic                 flush_rx,
    output logic                 flush_tx
);
    logic en_bit;
    logic flush_both;
    logic honour;

    assign en_bit     = wdata[CFG_EN_BIT];
    assign flush_both = wr & (~en_bit | (en_bit ^ fifo_en));
    assign honour     = wr & en_bit;
    assign flush_rx   = flush_both | (honour & wdata[CFG_RXF_BIT]);
    assign flush_tx   = flush_both | (honour & wdata[CFG_TXF_BIT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_en <= 1'b0;
        end else if (wr) begin
            fifo_en <= en_bit;
        end
    end

    assert_disable_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && !wdata[CFG_EN_BIT]) |=> !fifo_en);

endmodule

// File: rtl/ucf_ring.sv
module ucf_ring #(
    parameter  int WIDTH = 8,
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             single,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [CNT_W-1:0] count,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cap;
    logic             push_ok;
    logic             pop_ok;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign cap     = single ? CNT_W'(1) : CNT_W'(DEPTH);
    assign full    = (count >= cap);
    assign empty   = (count == '0);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wr_ptr] <= din;
        end
    end

    assert_flush_wins_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

    assert_level_bound_R5: assert property (@(posedge clk) disable iff (rst)
        count <= cap);

endmodule

// File: rtl/ucf_err_track.sv
module ucf_err_track #(
    parameter int CNT_W = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic inc,
    input  logic dec,
    output logic any_err
);
    logic [CNT_W-1:0] bad_cnt;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            bad_cnt <= '0;
        end else begin
            bad_cnt <= bad_cnt + CNT_W'(inc) - CNT_W'(dec);
        end
    end

    assign any_err = (bad_cnt != '0);

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
        (dec && !flush) |-> (bad_cnt != '0));

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr,
    input  logic [UCF_CFG_W-1:0]  cfg_wdata,
    input  logic                  tx_ie,
    input  logic                  rx_ie,
    input  logic                  tx_push,
    input  logic [UCF_DATA_W-1:0] tx_din,
    input  logic                  tx_pop,
    input  logic                  rx_push,
    input  logic [UCF_DATA_W-1:0] rx_din,
    input  logic                  rx_din_pe,
    input  logic                  rx_din_fe,
    input  logic                  rx_din_bi,
    input  logic                  rx_pop,
    input  logic                  lsr_clr,
    output logic                  fifo_mode,
    output logic [CNT_W-1:0]      tx_level,
    output logic [UCF_DATA_W-1:0] tx_head,
    output logic                  tx_req,
    output logic                  irq_tx_req,
    output logic [CNT_W-1:0]      rx_level,
    output logic [UCF_DATA_W-1:0] rx_head_data,
    output logic                  rx_head_pe,
    output logic                  rx_head_fe,
    output logic                  rx_head_bi,
    output logic                  data_ready,
    output logic                  fifo_err,
    output logic                  irq_rx_data,
    output logic                  ls_oe,
    output logic                  ls_pe,
    output logic                  ls_fe,
    output logic                  ls_bi
);
    localparam int RXW = $bits(rx_word_t);

    logic     flush_rx, flush_tx;
    logic     tx_full, tx_empty, rx_full, rx_empty;
    logic     rx_take, rx_give, rx_over;
    rx_word_t rx_in, rx_out;

    ucf_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .wdata    (cfg_wdata),
        .fifo_en  (fifo_mode),
        .flush_rx (flush_rx),
        .flush_tx (flush_tx)
    );

    ucf_ring #(.WIDTH(UCF_DATA_W), .DEPTH(DEPTH)) u_tx_ring (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush_tx),
        .single (~fifo_mode),
        .push   (tx_push),
        .pop    (tx_pop),
        .din    (tx_din),
        .count  (tx_level),
        .head   (tx_head),
        .full   (tx_full),
        .empty  (tx_empty)
    );

    assign rx_in = '{brk: rx_din_bi, ferr: rx_din_fe, perr: rx_din_pe, data: rx_din};

    ucf_ring #(.WIDTH(RXW), .DEPTH(DEPTH)) u_rx_ring (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush_rx),
        .single (~fifo_mode),
        .push   (rx_push),
        .pop    (rx_pop),
        .din    (rx_in),
        .count  (rx_level),
        .head   (rx_out),
        .full   (rx_full),
        .empty  (rx_empty)
    );

    assign rx_take = rx_push & ~rx_full & ~flush_rx;
    assign rx_over = rx_push & rx_full & ~flush_rx;
    assign rx_give = rx_pop & ~rx_empty & ~flush_rx;

    ucf_err_track #(.CNT_W(CNT_W)) u_err (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush_rx),
        .inc     (rx_take & rx_word_bad(rx_in)),
        .dec     (rx_give & rx_word_bad(rx_out)),
        .any_err (fifo_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ls_oe <= 1'b0;
            ls_pe <= 1'b0;
            ls_fe <= 1'b0;
            ls_bi <= 1'b0;
        end else begin
            ls_oe <= (ls_oe & ~lsr_clr) | rx_over;
            ls_pe <= (ls_pe & ~lsr_clr) | (rx_take & rx_din_pe);
            ls_fe <= (ls_fe & ~lsr_clr) | (rx_take & rx_din_fe);
            ls_bi <= (ls_bi & ~lsr_clr) | (rx_take & rx_din_bi);
        end
    end

    assign tx_req       = tx_empty;
    assign irq_tx_req   = tx_ie & tx_empty;
    assign data_ready   = ~rx_empty;
    assign irq_rx_data  = rx_ie & ~rx_empty;
    assign rx_head_data = rx_out.data;
    assign rx_head_pe   = rx_out.perr;
    assign rx_head_fe   = rx_out.ferr;
    assign rx_head_bi   = rx_out.brk;

    assert_tx_flush_req_R7: assert property (@(posedge clk) disable iff (rst)
        flush_tx |=> tx_req);

    assert_rx_flush_clean_R8: assert property (@(posedge clk) disable iff (rst)
        flush_rx |=> (!data_ready && !fifo_err));

    assert_sticky_keep_R8: assert property (@(posedge clk) disable iff (rst)
        (ls_pe && !lsr_clr) |=> ls_pe);

    assert_mode_flush_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(fifo_mode) |-> (rx_level == '0 && tx_level == '0));

endmodule

// File: tb/uart_fifo_ctrl_bench.sv
module uart_fifo_ctrl_bench;
    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr = 0;
    logic [2:0] cfg_wdata = 0;
    logic tx_ie = 0, rx_ie = 0, tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, lsr_clr = 0;
    logic [7:0] tx_din = 0, rx_din = 0;
    logic rx_din_pe = 0, rx_din_fe = 0, rx_din_bi = 0;
    logic fifo_mode, tx_req, irq_tx_req, data_ready, fifo_err, irq_rx_data;
    logic [CNT_W-1:0] tx_level, rx_level;
    logic [7:0] tx_head, rx_head_data;
    logic rx_head_pe, rx_head_fe, rx_head_bi, ls_oe, ls_pe, ls_fe, ls_bi;

    always #5 clk = ~clk;

    uart_fifo_ctrl #(.DEPTH(DEPTH)) u_uart_fifo_ctrl (.*);

    int checks = 0;
    int errors = 0;
    bit m_en = 0;
    bit m_oe = 0, m_pe = 0, m_fe = 0, m_bi = 0;
    logic [7:0]  m_tx[$];
    logic [10:0] m_rx[$];

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        int  cap = m_en ? DEPTH : 1;
        bit  all_f = cfg_wr && (!cfg_wdata[0] || (cfg_wdata[0] != m_en));
        bit  frx = all_f || (cfg_wr && cfg_wdata[0] && cfg_wdata[1]);
        bit  ftx = all_f || (cfg_wr && cfg_wdata[0] && cfg_wdata[2]);
        bit  rx_full = (m_rx.size() >= cap);
        bit  tx_full = (m_tx.size() >= cap);
        bit  take = rx_push && !rx_full && !frx;
        m_oe = (m_oe && !lsr_clr) || (rx_push && rx_full && !frx);
        m_pe = (m_pe && !lsr_clr) || (take && rx_din_pe);
        m_fe = (m_fe && !lsr_clr) || (take && rx_din_fe);
        m_bi = (m_bi && !lsr_clr) || (take && rx_din_bi);
        if (frx) m_rx.delete();
        else begin
            if (rx_pop && m_rx.size() > 0) void'(m_rx.pop_front());
            if (take) m_rx.push_back({rx_din_bi, rx_din_fe, rx_din_pe, rx_din});
        end
        if (ftx) m_tx.delete();
        else begin
            if (tx_pop && m_tx.size() > 0) void'(m_tx.pop_front());
            if (tx_push && !tx_full) m_tx.push_back(tx_din);
        end
        if (cfg_wr) m_en = cfg_wdata[0];
    endtask

    task automatic compare();
        bit any = 0;
        foreach (m_rx[i]) if (m_rx[i][10:8] != 0) any = 1;
        chk("R2", "fifo_mode", fifo_mode, m_en);
        chk("R5", "rx_level", rx_level, m_rx.size());
        chk("R5", "tx_level", tx_level, m_tx.size());
        chk("R7", "tx_req", tx_req, m_tx.size() == 0);
        chk("R7", "irq_tx_req", irq_tx_req, tx_ie && m_tx.size() == 0);
        chk("R8", "data_ready", data_ready, m_rx.size() != 0);
        chk("R8", "irq_rx_data", irq_rx_data, rx_ie && m_rx.size() != 0);
        chk("R9", "fifo_err", fifo_err, any);
        chk("R6", "ls_oe", ls_oe, m_oe);
        chk("R11", "ls_flags", {ls_pe, ls_fe, ls_bi}, {m_pe, m_fe, m_bi});
        if (m_rx.size() > 0)
            chk("R12", "rx_head", {rx_head_bi, rx_head_fe, rx_head_pe, rx_head_data}, m_rx[0]);
        if (m_tx.size() > 0)
            chk("R12", "tx_head", tx_head, m_tx[0]);
    endtask

    task automatic idle();
        cfg_wr = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; lsr_clr = 0;
        rx_din_pe = 0; rx_din_fe = 0; rx_din_bi = 0;
    endtask

    task automatic cyc();
        @(posedge clk);
        #1 model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic wr_cfg(logic [2:0] v);
        cfg_wr = 1; cfg_wdata = v; cyc(); idle();
    endtask

    task automatic push_rx(logic [7:0] d, logic [2:0] flags);
        rx_push = 1; rx_din = d; {rx_din_bi, rx_din_fe, rx_din_pe} = flags; cyc(); idle();
    endtask

    task automatic push_tx(logic [7:0] d);
        tx_push = 1; tx_din = d; cyc(); idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int keep;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", "fifo_mode", fifo_mode, 0);
        chk("R1", "levels", {rx_level, tx_level}, 0);
        chk("R1", "tx_req", tx_req, 1);
        chk("R1", "flags", {data_ready, fifo_err, ls_oe, ls_pe, ls_fe, ls_bi}, 0);

        wr_cfg(3'b001);
        chk("R3", "fifo_mode after enable", fifo_mode, 1);
        for (int i = 0; i < 18; i++) push_rx(8'(i + 8'h40), (i % 5 == 2) ? 3'(1 << (i % 3)) : 3'b000);
        chk("R6", "overrun after 18 pushes", ls_oe, 1);
        chk("R5", "rx full level", rx_level, DEPTH);
        for (int i = 0; i < 10; i++) push_tx(8'(i * 7));
        for (int i = 0; i < 3; i++) begin rx_pop = 1; tx_pop = 1; cyc(); idle(); end

        keep = tx_level;
        wr_cfg(3'b011);
        chk("R4", "tx level kept on rx flush", tx_level, keep);
        chk("R8", "sticky parity kept", ls_pe, 1);
        chk("R8", "data_ready cleared", data_ready, 0);

        push_rx(8'h11, 3'b000);
        tx_ie = 1;
        keep = rx_level;
        wr_cfg(3'b101);
        chk("R4", "rx level kept on tx flush", rx_level, keep);
        chk("R7", "irq_tx_req after tx flush", irq_tx_req, 1);
        wr_cfg(3'b001);
        chk("R4", "zero flush bits keep rx", rx_level, keep);

        rx_push = 1; rx_din = 8'hA5; rx_din_fe = 1; cfg_wr = 1; cfg_wdata = 3'b011; cyc(); idle();
        chk("R10", "flush beats push", rx_level, 0);
        chk("R10", "no error from lost push", fifo_err, 0);

        push_tx(8'h33);
        wr_cfg(3'b110);
        chk("R2", "disabled", fifo_mode, 0);
        chk("R2", "tx emptied", tx_level, 0);
        push_rx(8'h01, 3'b000);
        push_rx(8'h02, 3'b000);
        chk("R5", "single mode level", rx_level, 1);
        chk("R12", "single mode keeps first", rx_head_data, 8'h01);
        wr_cfg(3'b001);
        chk("R3", "enable empties rx", rx_level, 0);
        lsr_clr = 1; rx_push = 1; rx_din = 8'h5A; rx_din_bi = 1; cyc(); idle();
        chk("R11", "set wins over clear", ls_bi, 1);
        lsr_clr = 1; cyc(); idle();
        chk("R11", "clear", {ls_oe, ls_pe, ls_fe, ls_bi}, 0);

        for (int n = 0; n < 6000; n++) begin
            cfg_wr    = ($urandom % 40) == 0;
            cfg_wdata = 3'($urandom);
            if ($urandom % 4 != 0) cfg_wdata[0] = 1;
            if ($urandom % 50 == 0) tx_ie = ~tx_ie;
            if ($urandom % 50 == 0) rx_ie = ~rx_ie;
            tx_push   = ($urandom % 2) == 0;
            tx_din    = 8'($urandom);
            tx_pop    = ($urandom % 5) < 2;
            rx_push   = ($urandom % 2) == 0;
            rx_din    = 8'($urandom);
            rx_din_pe = ($urandom % 10) == 0;
            rx_din_fe = ($urandom % 10) == 0;
            rx_din_bi = ($urandom % 10) == 0;
            rx_pop    = ($urandom % 5) < 2;
            lsr_clr   = ($urandom % 20) == 0;
            cyc();
        end
        idle();
        cyc();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule